// File: doc/BRIEF.md
# Serial Bus Register Write Snooper

This block listens to a three-wire serial configuration bus (select, clock, data) that an outside processor drives. The processor uses that bus to program a configuration memory, or, when no memory is fitted, to program the device's own registers. The block does not drive the bus. It follows each select frame, decodes the instruction it carries, and turns each complete write into a single-cycle update request with an 8-bit address and a 16-bit data word for the internal register file. The live configuration therefore tracks every change the processor makes.

The three bus wires are brought into the system clock domain through two-stage synchronisers. Serial clock edges are found by comparing successive synchronised samples. Decoding is allowed only while the `arm` input is high. The system raises `arm` once the boot-time configuration load has finished.

A frame commits only after select has dropped and one more rising serial clock edge has arrived. The processor must supply that extra clock after every write.

Top module: `mw_write_snoop`

## Requirements
- R1: While reset is asserted and after it is released, `wr_strobe` is 0 and `wr_addr` and `wr_data` are all zeros until the first commit.
- R2: A frame begins with the first data bit equal to 1 that is sampled on a rising serial clock edge while select is high. Zero bits before it are skipped. After the start bit come 26 payload bits, MSB first: a 2-bit opcode, then an 8-bit address, then 16 data bits. The opcode value 01 means write, and only a write frame can commit its address and data.
- R3: Frames with opcode 00 (this covers the write-enable and write-disable commands), 10 or 11 never cause a strobe.
- R4: Each frame carries one instruction. Bits after the 26th payload bit are ignored. If a frame starts with a protection instruction and a write follows it inside the same select frame, no strobe results.
- R5: A complete write commits on the first rising serial clock edge seen while select is low after the frame. `wr_strobe` rises in the system clock cycle after that edge is detected. Without that edge there is no commit.
- R6: If select falls before all 26 payload bits have arrived, the frame is discarded and no strobe is produced.
- R7: Each committed frame gives exactly one strobe of one cycle. Further serial clock edges while select is low give no more strobes.
- R8: While `arm` is low, frames are not decoded, a pending write is dropped, and no strobe is produced. This also holds when `arm` is low in the same cycle as the commit edge.
- R9: If select rises again before the commit edge, or in the same cycle as it, the pending write is dropped.
- R10: `wr_addr` and `wr_data` change only in the cycle that `wr_strobe` is high. At all other times they keep the values of the last commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | High once the boot-time configuration load has finished |
| bus_cs | input | 1 | Serial bus select, asynchronous |
| bus_sk | input | 1 | Serial bus clock, asynchronous |
| bus_di | input | 1 | Serial bus data from the processor, asynchronous |
| wr_strobe | output | 1 | One-cycle register write request |
| wr_addr | output | 8 | Register address for the write |
| wr_data | output | 16 | Register data for the write |

## Verification
Two events can land in the same system clock cycle: the commit edge of a pending write, and either a new select rise or a drop of `arm`. The bench leaves a write pending. It then switches select and the serial clock high in the same time step, so both synchronised rises appear together, and checks that no strobe follows. It repeats this with `arm` lowered at the moment the serial clock rises. In both cases the expected outcome is that the write is dropped and the outputs keep the values of the last good commit.

// File: rtl/mw_snoop_pkg.sv
package mw_snoop_pkg;
  localparam int OP_W   = 2;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int PAY_W  = OP_W + ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(PAY_W + 1);
  localparam logic [OP_W-1:0] OP_WRITE = 2'b01;

  typedef enum logic [1:0] {
    ST_HUNT,   // waiting for start bit
    ST_SHIFT,  // collecting payload
    ST_FULL,   // payload complete, select still high
    ST_PEND    // write waiting for trailing clock
  } dec_state_e;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0] pipe [W];

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[b] <= '0;
      else        pipe[b] <= {pipe[b][STAGES-2:0], d[b]};
    end
    assign q[b] = pipe[b][STAGES-1];
  end
endmodule

// File: rtl/mw_frame_dec.sv
module mw_frame_dec
  import mw_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              cs_s,
  input  logic              sk_rise,
  input  logic              di_s,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  dec_state_e       state_q, state_n;
  logic [PAY_W-1:0] shreg_q, shreg_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             is_write;

  assign is_write    = (shreg_q[PAY_W-1 -: OP_W] == OP_WRITE);
  assign commit      = arm && (state_q == ST_PEND) && !cs_s && sk_rise;
  assign commit_addr = shreg_q[DATA_W +: ADDR_W];
  assign commit_data = shreg_q[DATA_W-1:0];

  always_comb begin
    state_n = state_q;
    shreg_n = shreg_q;
    cnt_n   = cnt_q;
    if (!arm) begin
      state_n = ST_HUNT;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (cs_s && sk_rise && di_s) begin
            state_n = ST_SHIFT;
            cnt_n   = '0;
          end
        end
        ST_SHIFT: begin
          if (!cs_s) begin
            state_n = ST_HUNT;
          end else if (sk_rise) begin
            shreg_n = {shreg_q[PAY_W-2:0], di_s};
            cnt_n   = cnt_q + 1'b1;
            if (cnt_q == CNT_W'(PAY_W - 1)) state_n = ST_FULL;
          end
        end
        ST_FULL: begin
          if (!cs_s) state_n = is_write ? ST_PEND : ST_HUNT;
        end
        ST_PEND: begin
          if (cs_s || sk_rise) state_n = ST_HUNT;
        end
        default: state_n = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      shreg_q <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/mw_write_snoop.sv
module mw_write_snoop
  import mw_snoop_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              bus_cs,
  input  logic              bus_sk,
  input  logic              bus_di,
  output logic              wr_strobe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic [2:0]        sync_q;
  logic              cs_s, sk_s, di_s, sk_d, sk_rise;
  logic              commit;
  logic [ADDR_W-1:0] c_addr, addr_n;
  logic [DATA_W-1:0] c_data, data_n;

  mw_sync #(.W(3), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_cs, bus_sk, bus_di}),
    .q     (sync_q)
  );
  assign {cs_s, sk_s, di_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sk_d <= 1'b0;
    else        sk_d <= sk_s;
  end
  assign sk_rise = sk_s && !sk_d;

  mw_frame_dec u_dec (
    .clk         (clk),
    .rst_n       (rst_n),
    .arm         (arm),
    .cs_s        (cs_s),
    .sk_rise     (sk_rise),
    .di_s        (di_s),
    .commit      (commit),
    .commit_addr (c_addr),
    .commit_data (c_data)
  );

  always_comb begin
    addr_n = wr_addr;
    data_n = wr_data;
    if (commit) begin
      addr_n = c_addr;
      data_n = c_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_strobe <= commit;
      wr_addr   <= addr_n;
      wr_data   <= data_n;
    end
  end
endmodule

// File: rtl/mw_snoop_chk.sv
module mw_snoop_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        arm,
  input logic        cs_s,
  input logic        sk_rise,
  input logic        wr_strobe,
  input logic [7:0]  wr_addr,
  input logic [15:0] wr_data
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe) else $error("strobe wider than one cycle"); // R7

  AST_STROBE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(sk_rise && !cs_s)) else $error("strobe without trailing edge"); // R5

  AST_STROBE_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> $past(arm)) else $error("strobe while disarmed"); // R8

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_addr) |-> wr_strobe) else $error("address moved without strobe"); // R10

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(wr_data) |-> wr_strobe) else $error("data moved without strobe"); // R10
endmodule

bind mw_write_snoop mw_snoop_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .arm       (arm),
  .cs_s      (cs_s),
  .sk_rise   (sk_rise),
  .wr_strobe (wr_strobe),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/test_mw_write_snoop.sv
module test_mw_write_snoop;
  logic clk, rst_n, arm, cs, sk, di;
  logic        wr_strobe;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int errs = 0, checks = 0, nwr = 0;
  logic [7:0]  cap_addr = '0;
  logic [15:0] cap_data = '0;
  bit done = 0;

  mw_write_snoop i_mw_write_snoop (
    .clk(clk), .rst_n(rst_n), .arm(arm), .bus_cs(cs), .bus_sk(sk), .bus_di(di),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  always @(negedge clk) if (rst_n && wr_strobe) begin
    nwr++;
    cap_addr = wr_addr;
    cap_data = wr_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    di = b; tick(4);
    sk = 1; tick(4);
    sk = 0;
  endtask

  task automatic trail(input int n);
    for (int i = 0; i < n; i++) begin
      tick(4); sk = 1; tick(4); sk = 0;
    end
    tick(10);
  endtask

  task automatic send_frame(input logic [1:0] op, input logic [7:0] a,
                            input logic [15:0] d, input int nbits, input int tail);
    logic [25:0] w;
    w = {op, a, d};
    cs = 1; tick(4);
    send_bit(1'b0);               // leading zero, skipped (R2)
    send_bit(1'b1);
    for (int i = 0; i < nbits; i++) send_bit(w[25-i]);
    tick(4); cs = 0; di = 0;
    trail(tail);
  endtask

  // {op[1:0], addr[7:0], data[15:0], nbits[4:0], tail[1:0], expect}
  localparam logic [33:0] VECS [8] = '{
    {2'b01, 8'h12, 16'hA55A, 5'd26, 2'd1, 1'b1},  // R2 write
    {2'b01, 8'hFF, 16'h0001, 5'd26, 2'd1, 1'b1},  // R2 top address
    {2'b00, 8'hC0, 16'h0000, 5'd10, 2'd1, 1'b0},  // R3 write enable
    {2'b01, 8'h34, 16'h1234, 5'd25, 2'd1, 1'b0},  // R6 short
    {2'b01, 8'h56, 16'h5678, 5'd26, 2'd0, 1'b0},  // R5 no trailing clock
    {2'b11, 8'h78, 16'hBEEF, 5'd26, 2'd1, 1'b0},  // R3 erase
    {2'b10, 8'h9A, 16'hCAFE, 5'd26, 2'd1, 1'b0},  // R3 read
    {2'b01, 8'h00, 16'hFFFF, 5'd26, 2'd3, 1'b1}   // R7 extra clocks
  };

  initial begin
    automatic int base;
    rst_n = 0; arm = 0; cs = 0; sk = 0; di = 0;
    tick(3);
    chk("R1 strobe", wr_strobe, 0);
    chk("R1 addr", wr_addr, 0);
    chk("R1 data", wr_data, 0);
    rst_n = 1; tick(3);
    chk("R1 after release", {wr_strobe, wr_addr, wr_data}, 0);

    // R8: disarmed frame ignored
    base = nwr;
    send_frame(2'b01, 8'h44, 16'h4444, 26, 1);
    chk("R8 disarmed", nwr - base, 0);
    chk("R8 outputs", {wr_addr, wr_data}, 0);
    arm = 1; tick(2);

    for (int v = 0; v < 8; v++) begin
      logic [33:0] e;
      logic [7:0]  pa;
      logic [15:0] pd;
      e = VECS[v]; pa = cap_addr; pd = cap_data; base = nwr;
      send_frame(e[33:32], e[31:24], e[23:8], int'(e[7:3]), int'(e[2:1]));
      chk($sformatf("R5 R7 vec%0d strobes", v), nwr - base, {31'b0, e[0]});
      if (e[0]) begin
        chk($sformatf("R2 vec%0d addr", v), wr_addr, e[31:24]);
        chk($sformatf("R2 vec%0d data", v), wr_data, e[23:8]);
      end else begin
        chk($sformatf("R10 vec%0d hold", v), {wr_addr, wr_data}, {pa, pd});
      end
    end

    // R4: enable instruction followed by write in one frame
    base = nwr;
    cs = 1; tick(4);
    send_bit(1); send_bit(0); send_bit(0);
    for (int i = 0; i < 8; i++) send_bit(i < 2);
    send_bit(1); send_bit(0); send_bit(1);
    for (int i = 0; i < 24; i++) send_bit(i[0]);
    tick(4); cs = 0; trail(1);
    chk("R4 merged frame", nwr - base, 0);

    // R9: select rise and trailing clock in the same cycle
    base = nwr;
    send_frame(2'b01, 8'h21, 16'h2121, 26, 0);
    di = 0; cs = 1; sk = 1; tick(6);
    sk = 0; tick(4); cs = 0; tick(4);
    trail(1);
    chk("R9 select rise beats commit", nwr - base, 0);
    chk("R10 hold after R9", {wr_addr, wr_data}, {8'h00, 16'hFFFF});

    // R8: arm drops at the commit edge
    base = nwr;
    send_frame(2'b01, 8'h31, 16'h3131, 26, 0);
    tick(4); sk = 1; tick(1); arm = 0; tick(4); sk = 0; tick(4);
    arm = 1; trail(1);
    chk("R8 disarm at commit edge", nwr - base, 0);

    // R2 after all corner cases still works
    base = nwr;
    send_frame(2'b01, 8'h5A, 16'h0F0F, 26, 1);
    chk("R2 final strobe", nwr - base, 1);
    chk("R2 final addr data", {wr_addr, wr_data}, {8'h5A, 16'h0F0F});

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule